// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

This block turns one IEEE-754 binary32 or binary64 value into a 32-bit or 64-bit integer. The integer can be signed or unsigned. The caller picks the rounding: round to nearest with ties to even, or truncate toward zero. The block is purely combinational. It unpacks the source, aligns the significand to the binary point, applies the rounding increment, clamps the magnitude to the destination range, and builds a small status vector beside the integer.

The special cases follow fixed rules. For an unsigned destination the sign test comes before rounding, so any negative nonzero input is invalid even if it would round to zero. A NaN gives all ones in a signed destination and zero in an unsigned one. Values too large for the destination clamp to the nearest limit. A result that lost fraction bits is flagged inexact, unless it was already flagged invalid.

Top module: `fp_to_int_sat`

## Requirements
- R1: `src_dbl`=1 reads binary64 from `src_bits[63:0]`. `src_dbl`=0 reads binary32 from `src_bits[31:0]` and ignores `src_bits[63:32]`. `dst_wide`=1 gives a 64-bit result. `dst_wide`=0 gives a 32-bit result in `int_out[31:0]` with `int_out[63:32]` forced to zero.
- R2: A finite value that is an exact integer and lies inside the destination range converts to that integer, with `status` all zero.
- R3: With `rnd_chop`=0 a value with a fraction rounds to the nearest integer. An exact half goes to the even neighbour.
- R4: With `rnd_chop`=1 the fraction is discarded, so the result moves toward zero.
- R5: Status bit 5 (inexact) is set when fraction bits were discarded and the result is not invalid. Status bit 1 (invalid) and bit 5 are never set together. Status bits 0, 2, 3 and 4 are always zero.
- R6: Any negative nonzero input with `dst_signed`=0 gives 0 and sets only bit 1. This holds in both rounding modes and at both widths, including magnitudes that would round to zero.
- R7: A NaN with `dst_signed`=1 gives all ones at the destination width and sets only bit 1. This holds for both source formats and both rounding modes.
- R8: A NaN with `dst_signed`=0 gives 0 and sets only bit 1.
- R9: A positive value, including +infinity, whose rounded magnitude exceeds the destination maximum gives that maximum and sets only bit 1. A negative value to a signed destination below the minimum, including -infinity, gives the minimum and sets only bit 1.
- R10: +0 and -0 give 0 with `status` all zero, for every destination.
- R11: A subnormal input is a tiny magnitude. It gives 0 with inexact, or 0 with invalid when it is negative and the destination is unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_dbl | input | 1 | 1: binary64 source, 0: binary32 source in the low half |
| src_bits | input | 64 | Floating-point source bits |
| dst_wide | input | 1 | 1: 64-bit integer result, 0: 32-bit |
| dst_signed | input | 1 | 1: two's complement result, 0: unsigned |
| rnd_chop | input | 1 | 1: truncate toward zero, 0: nearest, ties to even |
| int_out | output | 64 | Integer result, narrow results zero-extended |
| status | output | 6 | Bit 1 invalid, bit 5 inexact, others zero |

## Verification
The assertions are immediate checks on a combinational path. They assume every input is known (never X) and that all inputs change together, so each check sees a settled set of operands. The bench drives all five inputs in one step on the rising edge and samples on the falling edge. It sweeps signed quarter-step values and signed powers of two through both source formats and all eight destination and rounding combinations. It then adds NaNs, infinities, signed zeros, subnormals and values near the 32-bit and 64-bit limits. In binary32 runs the unused upper source half holds a nonzero pattern.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int DBL_BIAS   = 1023;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_BIAS   = 127;
  localparam int SRC_W      = 1 + DBL_EXP_W + DBL_FRAC_W;
  localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int SIG_W      = DBL_FRAC_W + 1;
  localparam int SGL_PAD    = DBL_FRAC_W - SGL_FRAC_W;
  localparam int EXP_W      = 13;
  localparam int INT_W      = 64;
  localparam int NARROW_W   = 32;
  localparam int MAG_W      = INT_W + 1;
  localparam int EXT_W      = 2 * INT_W;
  localparam int STATUS_W   = 6;
  localparam int FLAG_INVALID = 1;
  localparam int FLAG_INEXACT = 5;

  typedef struct packed {
    logic                    sign;
    logic                    nan;
    logic                    inf;
    logic                    zero;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } fp_fields_t;

  typedef struct packed {
    logic [INT_W-1:0] ipart;
    logic             rnd;
    logic             stk;
    logic             huge;
  } aligned_t;

  // Split either format into a common view: value = sig * 2^(exp - DBL_FRAC_W).
  function automatic fp_fields_t f_unpack(input logic is_dbl, input logic [SRC_W-1:0] bits);
    fp_fields_t u;
    logic [DBL_EXP_W-1:0]  de;
    logic [DBL_FRAC_W-1:0] df;
    logic [SGL_EXP_W-1:0]  se;
    logic [SGL_FRAC_W-1:0] sf;
    logic all1, all0, fz;
    int   e;
    de = bits[SRC_W-2 -: DBL_EXP_W];
    df = bits[DBL_FRAC_W-1:0];
    se = bits[SGL_W-2 -: SGL_EXP_W];
    sf = bits[SGL_FRAC_W-1:0];
    if (is_dbl) begin
      u.sign = bits[SRC_W-1];
      all1   = &de;
      all0   = ~|de;
      fz     = ~|df;
      e      = all0 ? (1 - DBL_BIAS) : (int'(de) - DBL_BIAS);
      u.sig  = {~all0, df};
    end else begin
      u.sign = bits[SGL_W-1];
      all1   = &se;
      all0   = ~|se;
      fz     = ~|sf;
      e      = all0 ? (1 - SGL_BIAS) : (int'(se) - SGL_BIAS);
      u.sig  = {~all0, sf, {SGL_PAD{1'b0}}};
    end
    u.nan  = all1 & ~fz;
    u.inf  = all1 & fz;
    u.zero = all0 & fz;
    u.exp  = EXP_W'(e);
    return u;
  endfunction

  // Place the binary point: integer part, first dropped bit, OR of the rest.
  function automatic aligned_t f_align(input logic nan, input logic inf,
                                       input logic signed [EXP_W-1:0] exp,
                                       input logic [SIG_W-1:0] sig);
    aligned_t         a;
    logic [EXT_W-1:0] ext;
    int               e;
    int               sh;
    a = '0;
    e = int'(exp);
    if (nan || inf || e >= INT_W) begin
      a.huge = 1'b1;
    end else if (e >= DBL_FRAC_W) begin
      a.ipart = INT_W'(sig) << (e - DBL_FRAC_W);
    end else begin
      sh = DBL_FRAC_W - e;
      if (sh > SIG_W) begin
        a.stk = |sig;
      end else begin
        ext     = {{(EXT_W-INT_W-SIG_W){1'b0}}, sig, {INT_W{1'b0}}} >> sh;
        a.ipart = ext[EXT_W-1:INT_W];
        a.rnd   = ext[INT_W-1];
        a.stk   = |ext[INT_W-2:0];
      end
    end
    return a;
  endfunction

  // Nearest-even increment decision; truncation never increments.
  function automatic logic f_bump(input logic chop, input logic lsb,
                                  input logic rnd, input logic stk);
    return ~chop & rnd & (stk | lsb);
  endfunction

  // Largest positive magnitude the destination can hold.
  function automatic logic [MAG_W-1:0] f_pos_max(input logic wide, input logic sgn);
    int w;
    w = wide ? INT_W : NARROW_W;
    return (MAG_W'(1) << (sgn ? w - 1 : w)) - MAG_W'(1);
  endfunction

  // Magnitude of the most negative signed value at the destination width.
  function automatic logic [MAG_W-1:0] f_neg_lim(input logic wide);
    int w;
    w = wide ? INT_W : NARROW_W;
    return MAG_W'(1) << (w - 1);
  endfunction
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic                    is_dbl,
  input  logic [SRC_W-1:0]        bits,
  output logic                    sign,
  output logic                    nan,
  output logic                    inf,
  output logic                    zero,
  output logic signed [EXP_W-1:0] exp,
  output logic [SIG_W-1:0]        sig
);
  fp_fields_t u;

  always_comb begin
    u    = f_unpack(is_dbl, bits);
    sign = u.sign;
    nan  = u.nan;
    inf  = u.inf;
    zero = u.zero;
    exp  = u.exp;
    sig  = u.sig;
  end

  always_comb begin
    a_r1_class_onehot: assert ($onehot0({nan, inf, zero}))
      else $error("unpack reports more than one class");
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
(
  input  logic                    nan,
  input  logic                    inf,
  input  logic signed [EXP_W-1:0] exp,
  input  logic [SIG_W-1:0]        sig,
  output logic [INT_W-1:0]        ipart,
  output logic                    rnd,
  output logic                    stk,
  output logic                    huge
);
  aligned_t a;

  always_comb begin
    a     = f_align(nan, inf, exp, sig);
    ipart = a.ipart;
    rnd   = a.rnd;
    stk   = a.stk;
    huge  = a.huge;
  end

  always_comb begin
    if (nan || inf) begin
      a_r9_special_is_huge: assert (huge && ipart == '0)
        else $error("special input not routed to saturation");
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  logic             chop,
  input  logic [INT_W-1:0] ipart,
  input  logic             rnd,
  input  logic             stk,
  output logic [MAG_W-1:0] mag,
  output logic             lost
);
  logic bump;

  always_comb begin
    bump = f_bump(chop, ipart[0], rnd, stk);
    mag  = {1'b0, ipart} + MAG_W'(bump);
    lost = rnd | stk;
  end

  always_comb begin
    if (chop) begin
      a_r4_chop_keeps_ipart: assert (mag == {1'b0, ipart})
        else $error("truncation changed the integer part");
    end
    a_r3_step_at_most_one: assert ((mag - {1'b0, ipart}) <= MAG_W'(1))
      else $error("rounding moved by more than one");
    if (!lost) begin
      a_r2_exact_unchanged: assert (mag == {1'b0, ipart})
        else $error("exact value was rounded");
    end
  end
endmodule

// File: rtl/f2i_saturate.sv
module f2i_saturate
  import f2i_pkg::*;
(
  input  logic             sign,
  input  logic             nan,
  input  logic             zero,
  input  logic             huge,
  input  logic [MAG_W-1:0] mag,
  input  logic             lost,
  input  logic             wide,
  input  logic             sgn,
  output logic [INT_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);
  logic [MAG_W-1:0] pos_max;
  logic [MAG_W-1:0] neg_lim;
  logic [INT_W-1:0] raw;
  logic [INT_W-1:0] keep;

  always_comb begin
    pos_max = f_pos_max(wide, sgn);
    neg_lim = f_neg_lim(wide);
    keep    = wide ? {INT_W{1'b1}} : INT_W'({NARROW_W{1'b1}});
    raw     = '0;
    invalid = 1'b0;
    if (nan) begin
      raw     = sgn ? {INT_W{1'b1}} : '0;
      invalid = 1'b1;
    end else if (sign && !zero && !sgn) begin
      raw     = '0;
      invalid = 1'b1;
    end else if (!sign) begin
      if (huge || mag > pos_max) begin
        raw     = pos_max[INT_W-1:0];
        invalid = 1'b1;
      end else begin
        raw = mag[INT_W-1:0];
      end
    end else begin
      if (huge || mag > neg_lim) begin
        raw     = neg_lim[INT_W-1:0];
        invalid = 1'b1;
      end else begin
        raw = (~mag[INT_W-1:0]) + INT_W'(1);
      end
    end
    result  = raw & keep;
    inexact = lost & ~invalid;
  end

  always_comb begin
    if (!nan && !sign && !huge && mag <= pos_max) begin
      a_r2_in_range_passes: assert (!invalid && result == mag[INT_W-1:0])
        else $error("in-range positive value altered");
    end
  end
endmodule

// File: rtl/fp_to_int_sat.sv
module fp_to_int_sat
  import f2i_pkg::*;
(
  input  logic                src_dbl,
  input  logic [SRC_W-1:0]    src_bits,
  input  logic                dst_wide,
  input  logic                dst_signed,
  input  logic                rnd_chop,
  output logic [INT_W-1:0]    int_out,
  output logic [STATUS_W-1:0] status
);
  logic                    f_sign, f_nan, f_inf, f_zero;
  logic signed [EXP_W-1:0] f_exp;
  logic [SIG_W-1:0]        f_sig;
  logic [INT_W-1:0]        al_ipart;
  logic                    al_rnd, al_stk, al_huge;
  logic [MAG_W-1:0]        rd_mag;
  logic                    rd_lost;
  logic                    sat_invalid, sat_inexact;

  // Named events for the checks below.
  logic             ev_nan;
  logic             ev_zero;
  logic             ev_neg_to_unsigned;
  logic [INT_W-1:0] width_ones;

  f2i_unpack u_unpack (
    .is_dbl (src_dbl),
    .bits   (src_bits),
    .sign   (f_sign),
    .nan    (f_nan),
    .inf    (f_inf),
    .zero   (f_zero),
    .exp    (f_exp),
    .sig    (f_sig)
  );

  f2i_align u_align (
    .nan   (f_nan),
    .inf   (f_inf),
    .exp   (f_exp),
    .sig   (f_sig),
    .ipart (al_ipart),
    .rnd   (al_rnd),
    .stk   (al_stk),
    .huge  (al_huge)
  );

  f2i_round u_round (
    .chop  (rnd_chop),
    .ipart (al_ipart),
    .rnd   (al_rnd),
    .stk   (al_stk),
    .mag   (rd_mag),
    .lost  (rd_lost)
  );

  f2i_saturate u_saturate (
    .sign    (f_sign),
    .nan     (f_nan),
    .zero    (f_zero),
    .huge    (al_huge),
    .mag     (rd_mag),
    .lost    (rd_lost),
    .wide    (dst_wide),
    .sgn     (dst_signed),
    .result  (int_out),
    .invalid (sat_invalid),
    .inexact (sat_inexact)
  );

  always_comb begin
    status               = '0;
    status[FLAG_INVALID] = sat_invalid;
    status[FLAG_INEXACT] = sat_inexact;
  end

  assign ev_nan             = f_nan;
  assign ev_zero            = f_zero;
  assign ev_neg_to_unsigned = f_sign & ~f_zero & ~f_nan & ~dst_signed;
  assign width_ones         = dst_wide ? {INT_W{1'b1}} : INT_W'({NARROW_W{1'b1}});

  always_comb begin
    if (ev_nan && dst_signed) begin
      a_r7_nan_signed_ones: assert (int_out == width_ones && status[FLAG_INVALID])
        else $error("NaN to signed not all ones");
    end
    if (ev_nan && !dst_signed) begin
      a_r8_nan_unsigned_zero: assert (int_out == '0 && status[FLAG_INVALID])
        else $error("NaN to unsigned not zero");
    end
    if (ev_neg_to_unsigned) begin
      a_r6_negative_unsigned: assert (int_out == '0 && status[FLAG_INVALID] && !status[FLAG_INEXACT])
        else $error("negative to unsigned not rejected");
    end
    if (ev_zero) begin
      a_r10_zero_clean: assert (int_out == '0 && status == '0)
        else $error("zero input produced output or flags");
    end
    a_r5_flags_exclusive: assert (!(status[FLAG_INVALID] && status[FLAG_INEXACT]))
      else $error("invalid and inexact both set");
    if (!dst_wide) begin
      a_r1_narrow_upper_clear: assert (int_out[INT_W-1:NARROW_W] == '0)
        else $error("narrow result leaks into upper half");
    end
  end
endmodule

// File: tb/fp_to_int_sat_bench.sv
module fp_to_int_sat_bench;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        src_dbl = 1'b0;
  logic [63:0] src_bits = '0;
  logic        dst_wide = 1'b0;
  logic        dst_signed = 1'b0;
  logic        rnd_chop = 1'b0;
  logic [63:0] int_out;
  logic [5:0]  status;
  int          n_checks = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_to_int_sat u_fp_to_int_sat (
    .src_dbl    (src_dbl),
    .src_bits   (src_bits),
    .dst_wide   (dst_wide),
    .dst_signed (dst_signed),
    .rnd_chop   (rnd_chop),
    .int_out    (int_out),
    .status     (status)
  );

  function automatic real f_pow2(input int k);
    real r = 1.0;
    for (int i = 0; i < k; i++) r = r * 2.0;
    return r;
  endfunction

  // Binary32 encoding of a value that binary32 represents exactly.
  function automatic logic [63:0] f_single_bits(input real v);
    logic [63:0] d = $realtobits(v);
    if (d[62:0] == '0) return {32'b0, d[63], 31'b0};
    return {32'b0, d[63], 8'(int'(d[62:52]) - 896), d[51:29]};
  endfunction

  function automatic real f_rne(input real a);
    real f = $floor(a);
    real d = a - f;
    if (d > 0.5) return f + 1.0;
    if (d == 0.5 && ($floor(f / 2.0) * 2.0 != f)) return f + 1.0;
    return f;
  endfunction

  function automatic logic [63:0] f_to_u64(input real a);
    if (a >= f_pow2(63)) return {1'b1, 63'(longint'(a - f_pow2(63)))};
    return 64'(longint'(a));
  endfunction

  task automatic model(input real v, input bit nan, input bit wide, input bit sgn,
                       input bit chop, output logic [63:0] r, output logic [5:0] st,
                       output string vtag, output string stag);
    int          w = wide ? 64 : 32;
    real         a, q;
    logic [63:0] m;
    logic [63:0] keep = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    st = '0;
    if (nan) begin
      r = sgn ? '1 : '0; st[1] = 1'b1;
      vtag = sgn ? "R7" : "R8"; stag = vtag;
    end else if (v < 0.0 && !sgn) begin
      r = '0; st[1] = 1'b1; vtag = "R6"; stag = "R6";
    end else begin
      a = (v < 0.0) ? -v : v;
      q = chop ? $floor(a) : f_rne(a);
      if (v >= 0.0 && q >= f_pow2(sgn ? w - 1 : w)) begin
        r = sgn ? ((64'(1) << (w - 1)) - 64'(1)) : '1;
        st[1] = 1'b1; vtag = "R9"; stag = "R9";
      end else if (v < 0.0 && q > f_pow2(w - 1)) begin
        r = 64'(1) << (w - 1);
        st[1] = 1'b1; vtag = "R9"; stag = "R9";
      end else begin
        m = f_to_u64(q);
        r = (v < 0.0) ? -m : m;
        st[5] = (q != a);
        if (v == 0.0) vtag = "R10";
        else if (q == a) vtag = "R2";
        else vtag = chop ? "R4" : "R3";
        stag = (v == 0.0) ? "R10" : "R5";
      end
    end
    r = r & keep;
  endtask

  task automatic check64(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%016h expected 0x%016h", tag, what, got, exp);
    end
  endtask

  // Apply one source under all eight destination and rounding combinations.
  task automatic run(input logic [63:0] bits, input bit dbl, input real v,
                     input bit nan, input string override);
    logic [63:0] er;
    logic [5:0]  est;
    string       vtag, stag;
    for (int wi = 0; wi < 2; wi++) begin
      for (int si = 0; si < 2; si++) begin
        for (int ci = 0; ci < 2; ci++) begin
          model(v, nan, wi[0], si[0], ci[0], er, est, vtag, stag);
          if (override != "") begin vtag = override; stag = override; end
          @(posedge clk);
          src_dbl    = dbl;
          src_bits   = dbl ? bits : {32'hA5C3_3C5A, bits[31:0]};
          dst_wide   = wi[0];
          dst_signed = si[0];
          rnd_chop   = ci[0];
          @(negedge clk);
          check64(vtag, "value", int_out, er);
          check64(stag, "status", {58'b0, status}, {58'b0, est});
          if (wi == 0) check64("R1", "upper half", {32'b0, int_out[63:32]}, 64'b0);
        end
      end
    end
  endtask

  task automatic run_both(input real v);
    run($realtobits(v), 1'b1, v, 1'b0, "");
    run(f_single_bits(v), 1'b0, v, 1'b0, "");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    // Reset-free block: all-zero inputs are +0 binary32, narrow unsigned (R10).
    check64("R10", "idle value", int_out, 64'b0);
    check64("R10", "idle status", {58'b0, status}, 64'b0);

    // R2 R3 R4 R5 R6: signed quarter steps, covering ties and fractions.
    for (int n = -300; n <= 300; n++) begin
      for (int q = 0; q < 4; q++) begin
        run_both(real'(n) + 0.25 * real'(q));
      end
    end

    // R9: signed powers of two and 1.5 multiples across both width limits.
    for (int k = 0; k <= 70; k++) begin
      run_both(f_pow2(k));
      run_both(-f_pow2(k));
      run_both(1.5 * f_pow2(k));
      run_both(-1.5 * f_pow2(k));
    end

    // R9 R3 R4: binary64 values right at the 32-bit and 64-bit edges.
    run($realtobits(2147483647.0), 1'b1, 2147483647.0, 1'b0, "");
    run($realtobits(2147483647.5), 1'b1, 2147483647.5, 1'b0, "");
    run($realtobits(4294967295.5), 1'b1, 4294967295.5, 1'b0, "");
    run($realtobits(-2147483648.0), 1'b1, -2147483648.0, 1'b0, "");
    run($realtobits(-2147483648.5), 1'b1, -2147483648.5, 1'b0, "");
    run($realtobits(-2147483649.0), 1'b1, -2147483649.0, 1'b0, "");
    run(64'h43EF_FFFF_FFFF_FFFF, 1'b1, $bitstoreal(64'h43EF_FFFF_FFFF_FFFF), 1'b0, "");
    run(64'h43DF_FFFF_FFFF_FFFF, 1'b1, $bitstoreal(64'h43DF_FFFF_FFFF_FFFF), 1'b0, "");

    // R7 R8: quiet, signalling and negative NaNs in both formats.
    run(64'h0000_0000_7FC0_0000, 1'b0, 0.0, 1'b1, "");
    run(64'h0000_0000_7F80_0001, 1'b0, 0.0, 1'b1, "");
    run(64'h0000_0000_FFFF_FFFF, 1'b0, 0.0, 1'b1, "");
    run(64'h7FF8_0000_0000_0000, 1'b1, 0.0, 1'b1, "");
    run(64'h7FF7_0000_0000_0000, 1'b1, 0.0, 1'b1, "");
    run(64'hFFF8_0000_0000_0001, 1'b1, 0.0, 1'b1, "");

    // R9 R6: infinities.
    run(64'h0000_0000_7F80_0000, 1'b0, 1.0e300, 1'b0, "");
    run(64'h0000_0000_FF80_0000, 1'b0, -1.0e300, 1'b0, "");
    run(64'h7FF0_0000_0000_0000, 1'b1, 1.0e300, 1'b0, "");
    run(64'hFFF0_0000_0000_0000, 1'b1, -1.0e300, 1'b0, "");

    // R10: negative zero.
    run(64'h0000_0000_8000_0000, 1'b0, 0.0, 1'b0, "R10");
    run(64'h8000_0000_0000_0000, 1'b1, 0.0, 1'b0, "R10");

    // R11: subnormals of both signs.
    run(64'h0000_0000_0000_0001, 1'b0, 1.0e-40, 1'b0, "R11");
    run(64'h0000_0000_8000_0001, 1'b0, -1.0e-40, 1'b0, "R11");
    run(64'h0000_0000_007F_FFFF, 1'b0, 1.0e-40, 1'b0, "R11");
    run(64'h0000_0000_0000_0001, 1'b1, 1.0e-40, 1'b0, "R11");
    run(64'h8000_0000_0000_0001, 1'b1, -1.0e-40, 1'b0, "R11");

    // R6: tiny negative normals that would round to zero.
    run(64'h0000_0000_AB98_FBA8, 1'b0, -1.0e-12, 1'b0, "");
    run(64'hBD73_1F75_0000_0000, 1'b1, -1.0e-12, 1'b0, "");

    summary();
    $finish;
  end
endmodule